// File: doc/BRIEF.md
# Scalar Float Compare Flag Unit

This unit compares two IEEE-754 single-precision values and reports the outcome as a three-bit zero/parity/carry flag code. The other three flag outputs (overflow, sign, auxiliary carry) are always cleared. Each operand arrives on a wide input word, and only its low 32 bits are compared. A mode input chooses quiet-unordered behaviour or signalling-ordered behaviour, and that choice changes which NaNs raise an invalid indication.

The unit also flags subnormal operands. Both exception indications are checked against per-exception mask bits. When an exception is raised and its mask bit is clear, the flag register keeps its old contents and an unmasked-exception output is raised alongside the result. The interface is a single registered stage: a request presented with `in_valid` produces a one-cycle `out_valid` pulse on the next clock.

Top module: `fcmp_flags`

## Requirements
- R1: Only bits [31:0] of `opa` and `opb` are compared; bits above 31 never change any output.
- R2: If either operand is a NaN (exponent all ones, fraction nonzero), quiet or signalling, the flag code {zero,parity,carry} is 3'b111.
- R3: For ordered operands the flag code is 3'b000 when opa > opb, 3'b001 when opa < opb, and 3'b100 when they are equal.
- R4: Every flag update drives the overflow, sign and auxiliary-carry flags to 0.
- R5: With `mode_ordered`=0, `exc_invalid` is raised only when an operand is a signalling NaN (fraction bit 22 = 0). A quiet NaN (bit 22 = 1) does not raise it.
- R6: With `mode_ordered`=1, `exc_invalid` is raised when either operand is any NaN.
- R7: `exc_denorm` is raised when either operand is subnormal (exponent zero, fraction nonzero).
- R8: If a raised exception has its mask bit clear, `exc_unmasked` is 1 and all six flags keep their previous values. If every raised exception is masked, the flags update normally.
- R9: `out_valid` is high in exactly the cycle after an `in_valid` cycle. The flags and exception outputs change in that same cycle.
- R10: +0 and -0 compare equal. Subnormals are compared by value, with no flush to zero.
- R11: For non-NaN operands with different signs, the positive one is greater. With both negative, the magnitude ordering is inverted.
- R12: After reset, `out_valid`, all flags and all exception outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| mode_ordered | input | 1 | 1 = signalling-ordered, 0 = quiet-unordered |
| opa | input | OPW | First operand word; low 32 bits used |
| opb | input | OPW | Second operand word; low 32 bits used |
| mask_invalid | input | 1 | 1 masks the invalid exception |
| mask_denorm | input | 1 | 1 masks the denormal exception |
| out_valid | output | 1 | Result strobe, one cycle after request |
| flag_zero | output | 1 | Zero flag |
| flag_parity | output | 1 | Parity flag |
| flag_carry | output | 1 | Carry flag |
| flag_ovf | output | 1 | Overflow flag, cleared on update |
| flag_sign | output | 1 | Sign flag, cleared on update |
| flag_aux | output | 1 | Auxiliary-carry flag, cleared on update |
| exc_invalid | output | 1 | Invalid indication for this result |
| exc_denorm | output | 1 | Denormal indication for this result |
| exc_unmasked | output | 1 | A raised exception was not masked; flags held |

## Verification
A single request can need a flag update and the hold caused by an unmasked exception, and the hold must win. A request can also raise invalid and denormal together. The bench first loads a known flag code. It then sends a signalling NaN against a subnormal operand with invalid masked and denormal unmasked. It checks that both indications appear, that the unmasked output is set by the denormal alone, and that the earlier code survives. A masked counterpart of that case confirms that masked exceptions still let the unordered code through.

// File: rtl/fcmp_flags.sv
module fcmp_flags #(
  parameter int OPW = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           mode_ordered,
  input  logic [OPW-1:0] opa,
  input  logic [OPW-1:0] opb,
  input  logic           mask_invalid,
  input  logic           mask_denorm,
  output logic           out_valid,
  output logic           flag_zero,
  output logic           flag_parity,
  output logic           flag_carry,
  output logic           flag_ovf,
  output logic           flag_sign,
  output logic           flag_aux,
  output logic           exc_invalid,
  output logic           exc_denorm,
  output logic           exc_unmasked
);
  localparam int FW    = 32;
  localparam int FRACW = 23;
  localparam int EXPW  = FW - FRACW - 1;
  localparam int QBIT  = FRACW - 1;
  localparam int MAGW  = FW - 1;

  localparam logic [2:0] C_UNORD = 3'b111;
  localparam logic [2:0] C_GT    = 3'b000;
  localparam logic [2:0] C_LT    = 3'b001;
  localparam logic [2:0] C_EQ    = 3'b100;

  logic [FW-1:0] a, b;
  assign a = opa[FW-1:0];
  assign b = opb[FW-1:0];

  logic hi_unused;
  assign hi_unused = ^{opa[OPW-1:FW], opb[OPW-1:FW]};

  function automatic logic f_nan(input logic [FW-1:0] v);
    return (&v[FW-2:FRACW]) && (|v[FRACW-1:0]);
  endfunction

  function automatic logic f_snan(input logic [FW-1:0] v);
    return f_nan(v) && !v[QBIT];
  endfunction

  function automatic logic f_sub(input logic [FW-1:0] v);
    return (v[FW-2:FRACW] == '0) && (|v[FRACW-1:0]);
  endfunction

  logic any_nan, any_snan, any_sub;
  assign any_nan  = f_nan(a)  || f_nan(b);
  assign any_snan = f_snan(a) || f_snan(b);
  assign any_sub  = f_sub(a)  || f_sub(b);

  logic [MAGW-1:0] mag_a, mag_b;
  assign mag_a = a[MAGW-1:0];
  assign mag_b = b[MAGW-1:0];

  logic [2:0] code;
  always_comb begin
    if (any_nan)                          code = C_UNORD;
    else if (mag_a == '0 && mag_b == '0)  code = C_EQ;
    else if (a[FW-1] != b[FW-1])          code = a[FW-1] ? C_LT : C_GT;
    else if (mag_a == mag_b)              code = C_EQ;
    else if ((mag_a > mag_b) ^ a[FW-1])   code = C_GT;
    else                                  code = C_LT;
  end

  logic inv_raw, unm_raw;
  assign inv_raw = mode_ordered ? any_nan : any_snan;
  assign unm_raw = (inv_raw && !mask_invalid) || (any_sub && !mask_denorm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      exc_invalid  <= 1'b0;
      exc_denorm   <= 1'b0;
      exc_unmasked <= 1'b0;
      {flag_zero, flag_parity, flag_carry} <= 3'b000;
      {flag_ovf, flag_sign, flag_aux}      <= 3'b000;
    end else begin
      out_valid    <= in_valid;
      exc_invalid  <= in_valid && inv_raw;
      exc_denorm   <= in_valid && any_sub;
      exc_unmasked <= in_valid && unm_raw;
      if (in_valid && !unm_raw) begin
        {flag_zero, flag_parity, flag_carry} <= code;
        {flag_ovf, flag_sign, flag_aux}      <= 3'b000;
      end
    end
  end

  p_legal_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_parity |-> (flag_zero && flag_carry));

  p_clear_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !exc_unmasked) |-> !(flag_ovf || flag_sign || flag_aux));

  p_quiet_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_ordered && !any_snan) |=> !exc_invalid);

  p_ord_inv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_ordered && any_nan) |=> exc_invalid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exc_unmasked) |->
      $stable({flag_zero, flag_parity, flag_carry, flag_ovf, flag_sign, flag_aux}));

  p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_exc_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_unmasked || exc_invalid || exc_denorm) |-> out_valid);

  p_unord_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && any_nan && !unm_raw) |=> (flag_zero && flag_parity && flag_carry));
endmodule

// File: tb/fcmp_flags_bench.sv
`timescale 1ns/1ps
module fcmp_flags_bench;
  localparam int OPW = 64;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, mode_ordered = 1'b0;
  logic [OPW-1:0] opa = '0, opb = '0;
  logic mask_invalid = 1'b1, mask_denorm = 1'b1;
  logic out_valid, flag_zero, flag_parity, flag_carry, flag_ovf, flag_sign, flag_aux;
  logic exc_invalid, exc_denorm, exc_unmasked;
  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  fcmp_flags #(.OPW(OPW)) u_fcmp_flags (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_ordered(mode_ordered),
    .opa(opa), .opb(opb), .mask_invalid(mask_invalid), .mask_denorm(mask_denorm),
    .out_valid(out_valid), .flag_zero(flag_zero), .flag_parity(flag_parity),
    .flag_carry(flag_carry), .flag_ovf(flag_ovf), .flag_sign(flag_sign),
    .flag_aux(flag_aux), .exc_invalid(exc_invalid), .exc_denorm(exc_denorm),
    .exc_unmasked(exc_unmasked));

  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
  localparam logic [31:0] N1 = 32'hBF80_0000, N2 = 32'hC000_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] QN = 32'h7FC0_0000, SN = 32'h7F80_0001;
  localparam logic [31:0] D1 = 32'h0000_0001, D2 = 32'h0000_0002;
  localparam logic [31:0] INF = 32'h7F80_0000;

  function automatic logic [2:0] zpc();
    return {flag_zero, flag_parity, flag_carry};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic ord,
                     input logic mi, input logic md,
                     input logic [31:0] ha = 32'h0, input logic [31:0] hb = 32'h0);
    @(negedge clk);
    opa = {ha, a}; opb = {hb, b}; mode_ordered = ord;
    mask_invalid = mi; mask_denorm = md; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 valid", {7'd0, out_valid}, 8'd0);
    chk("R12 flags", {2'd0, zpc(), flag_ovf, flag_sign, flag_aux}, 8'd0);
    chk("R12 exc", {5'd0, exc_invalid, exc_denorm, exc_unmasked}, 8'd0);
  endtask

  task automatic t_basic_codes();
    run(P2, P1, 0, 1, 1);
    chk("R3 gt", {5'd0, zpc()}, 8'b000);
    chk("R9 valid", {7'd0, out_valid}, 8'd1);
    chk("R4 cleared", {5'd0, flag_ovf, flag_sign, flag_aux}, 8'd0);
    @(negedge clk);
    chk("R9 single pulse", {7'd0, out_valid}, 8'd0);
    run(P1, P2, 0, 1, 1);
    chk("R3 lt", {5'd0, zpc()}, 8'b001);
    run(P1, P1, 0, 1, 1);
    chk("R3 eq", {5'd0, zpc()}, 8'b100);
  endtask

  task automatic t_high_bits();
    run(P1, P1, 0, 1, 1, 32'hDEAD_BEEF, 32'h1234_5678);
    chk("R1 high ignored", {5'd0, zpc()}, 8'b100);
    run(P2, P1, 0, 0, 0, 32'h7FC0_0000, 32'h0000_0001);
    chk("R1 high no exc", {5'd0, exc_invalid, exc_denorm, exc_unmasked}, 8'd0);
    chk("R1 high gt", {5'd0, zpc()}, 8'b000);
  endtask

  task automatic t_signs();
    run(N1, P1, 0, 1, 1);
    chk("R11 neg<pos", {5'd0, zpc()}, 8'b001);
    run(N2, N1, 0, 1, 1);
    chk("R11 -2<-1", {5'd0, zpc()}, 8'b001);
    run(N1, N2, 0, 1, 1);
    chk("R11 -1>-2", {5'd0, zpc()}, 8'b000);
    run(INF, P2, 0, 1, 1);
    chk("R11 inf>2", {5'd0, zpc()}, 8'b000);
  endtask

  task automatic t_zero_sub();
    run(PZ, NZ, 0, 1, 1);
    chk("R10 +0==-0", {5'd0, zpc()}, 8'b100);
    run(D2, D1, 0, 1, 1);
    chk("R10 sub order", {5'd0, zpc()}, 8'b000);
    chk("R7 denorm masked", {5'd0, exc_invalid, exc_denorm, exc_unmasked}, 8'b010);
    run(D1, PZ, 0, 1, 1);
    chk("R10 sub>0", {5'd0, zpc()}, 8'b000);
  endtask

  task automatic t_nans();
    run(QN, P1, 0, 0, 1);
    chk("R2 qnan unord", {5'd0, zpc()}, 8'b111);
    chk("R5 qnan quiet no inv", {5'd0, exc_invalid, exc_denorm, exc_unmasked}, 8'd0);
    run(P1, P2, 0, 1, 1);
    run(P1, SN, 0, 1, 1);
    chk("R2 snan unord", {5'd0, zpc()}, 8'b111);
    chk("R5 snan quiet inv", {5'd0, exc_invalid, exc_denorm, exc_unmasked}, 8'b100);
    run(QN, P1, 1, 1, 1);
    chk("R6 qnan ordered inv", {5'd0, exc_invalid, exc_denorm, exc_unmasked}, 8'b100);
    chk("R6 flags", {5'd0, zpc()}, 8'b111);
  endtask

  task automatic t_unmasked_hold();
    run(P2, P1, 0, 1, 1);
    run(SN, P1, 0, 0, 1);
    chk("R8 inv unmasked", {5'd0, exc_invalid, exc_denorm, exc_unmasked}, 8'b101);
    chk("R8 flags held", {2'd0, zpc(), flag_ovf, flag_sign, flag_aux}, 8'd0);
    run(P1, P2, 0, 1, 1);
    run(QN, P1, 1, 0, 1);
    chk("R8 ord unmasked", {5'd0, exc_invalid, exc_denorm, exc_unmasked}, 8'b101);
    chk("R8 held lt", {5'd0, zpc()}, 8'b001);
    run(D1, P1, 0, 1, 0);
    chk("R8 denorm unmasked", {5'd0, exc_invalid, exc_denorm, exc_unmasked}, 8'b011);
    chk("R8 held lt 2", {5'd0, zpc()}, 8'b001);
  endtask

  task automatic t_both_exc();
    run(P1, P1, 0, 1, 1);
    run(SN, D1, 0, 1, 0);
    chk("R8 both exc", {5'd0, exc_invalid, exc_denorm, exc_unmasked}, 8'b111);
    chk("R8 both held", {5'd0, zpc()}, 8'b100);
    run(SN, D1, 0, 1, 1);
    chk("R8 both masked", {5'd0, exc_invalid, exc_denorm, exc_unmasked}, 8'b110);
    chk("R2 both masked unord", {5'd0, zpc()}, 8'b111);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic_codes();
    t_high_bits();
    t_signs();
    t_zero_sub();
    t_nans();
    t_unmasked_hold();
    t_both_exc();
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule